// File: doc/BRIEF.md
# Shared SRAM Two-Requester Arbiter

This block sits in front of one single-ported synchronous SRAM array and shares it between two requesters. One is the processor port; the other is a backdoor port, for example a path from the system bus. In each cycle it picks at most one requester and drives the array with that requester's address, write enable and write data. Read data comes back one cycle later, together with a valid strobe that goes only to the requester that was granted.

A 2-bit mode input chooses the policy at run time. The choices are plain alternation, an alternation weighted toward the backdoor, and fixed priority in either direction. A write-lock input suppresses every write to the array. A write that is refused still receives its grant, but the requester gets a one-cycle error flag in the cycle after the grant. Each half of a split memory uses its own instance, so the mode and the lock are separate per instance and two instances can run different policies at the same time.

Top module: `sram_port_arbiter`

## Requirements
- R1: While `rst_n` is low, no grant is given, even when both requests are high. In the first cycle after reset, `cpu_rvalid`, `bdr_rvalid`, `cpu_err` and `bdr_err` are 0. The arbitration history leaves reset so that the first contested cycle in mode 00 goes to the processor.
- R2: At most one grant is high in any cycle. A request that is alone is granted in the same cycle, in every mode. `mem_en` equals the OR of the two grants.
- R3: Mode 2'b00 is plain round robin. A contested cycle goes to the requester that did not receive the most recent grant, counting every grant, contested or not.
- R4: Mode 2'b01 is a round robin weighted toward the backdoor. The processor wins a contested cycle only when the two most recent grants both went to the backdoor; otherwise the backdoor wins. Under continuous contention this gives backdoor, backdoor, processor, repeating.
- R5: Mode 2'b10 is fixed priority with the processor always winning a contested cycle.
- R6: Mode 2'b11 is fixed priority with the backdoor always winning a contested cycle.
- R7: While `wr_lock` is 1, `mem_we` stays 0, so the array contents do not change. A granted write is still granted. The requester's error flag is 1 for exactly the cycle after that grant. An unlocked write raises no error.
- R8: A granted read raises the granted requester's `*_rvalid` for the following cycle only. In that cycle the requester's `*_rdata` carries the word the array returns; the other requester's valid stays 0. A write raises no valid.
- R9: A change of mode takes effect at the very next arbitration. The grant history built up under earlier modes is kept across the change.
- R10: In a cycle with a grant, `mem_addr` and `mem_wdata` carry the granted requester's address and write data. A unlocked granted write drives `mem_we` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 2 | Arbitration policy: 00 round robin, 01 backdoor-weighted, 10 processor first, 11 backdoor first |
| wr_lock | input | 1 | Write lock; 1 suppresses array writes |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | Processor write enable (1 = write) |
| cpu_addr | input | AW | Processor word address |
| cpu_wdata | input | DW | Processor write data |
| cpu_gnt | output | 1 | Processor granted this cycle |
| cpu_rdata | output | DW | Processor read data, valid with cpu_rvalid, else 0 |
| cpu_rvalid | output | 1 | Processor read data valid |
| cpu_err | output | 1 | Processor write was refused by the lock |
| bdr_req | input | 1 | Backdoor access request |
| bdr_we | input | 1 | Backdoor write enable (1 = write) |
| bdr_addr | input | AW | Backdoor word address |
| bdr_wdata | input | DW | Backdoor write data |
| bdr_gnt | output | 1 | Backdoor granted this cycle |
| bdr_rdata | output | DW | Backdoor read data, valid with bdr_rvalid, else 0 |
| bdr_rvalid | output | 1 | Backdoor read data valid |
| bdr_err | output | 1 | Backdoor write was refused by the lock |
| mem_en | output | 1 | Array access strobe |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | AW | Array address |
| mem_wdata | output | DW | Array write data |
| mem_rdata | input | DW | Array read data, one cycle after a read strobe |

## Verification
The hardest situation to set up from the ports is a contested cycle whose outcome depends on a history left behind by an earlier mode. Examples are a weighted round robin that follows two backdoor grants, one of them made under fixed priority, or a plain round robin that follows an uncontested processor grant. The stimulus table reaches these states with a planned run of contested and lone requests. It switches `mode_sel` in the middle of the run without resetting, and the expected winner of each row is worked out from the history that the earlier rows produce. Directed tests then write, lock and read back one address to show that a refused write leaves the word unchanged.

// File: rtl/sram_arb_pkg.sv
// Shared definitions for the two-requester SRAM arbiter.
// Assumes exactly two requesters: index 0 is the processor, index 1 the backdoor.
package sram_arb_pkg;

    // Arbitration policy selected by the 2-bit mode input.
    typedef enum logic [1:0] {
        ARB_ROUND     = 2'b00,
        ARB_ROUND_BDR = 2'b01,
        ARB_FIX_CPU   = 2'b10,
        ARB_FIX_BDR   = 2'b11
    } arb_mode_e;

    localparam int NUM_PORTS = 2;
    localparam int PORT_CPU  = 0;
    localparam int PORT_BDR  = 1;

endpackage

// File: rtl/arb_policy.sv
// Grant decision for the two requesters.
// The grant is combinational from the requests, so a lone request is served in the
// same cycle. The history is a saturating count of consecutive backdoor grants
// (0 = processor had the last grant). Every policy reads this one counter, and a
// mode change never clears it.
// Assumes BDR_RUN >= 1; BDR_RUN is how many contested wins the backdoor may take
// in a row in the weighted mode.
module arb_policy
    import sram_arb_pkg::*;
#(
    parameter int BDR_RUN = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  arb_mode_e            mode,
    input  logic [NUM_PORTS-1:0] req,
    output logic [NUM_PORTS-1:0] gnt
);
    localparam int RUN_W = $clog2(BDR_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(BDR_RUN);

    logic [RUN_W-1:0] bdr_run;
    logic             cpu_first;
    logic             contested;

    assign contested = req[PORT_CPU] & req[PORT_BDR];

    // Which requester wins a contested cycle under the current policy.
    always_comb begin
        case (mode)
            ARB_ROUND:     cpu_first = (bdr_run != '0);
            ARB_ROUND_BDR: cpu_first = (bdr_run == RUN_MAX);
            ARB_FIX_CPU:   cpu_first = 1'b1;
            default:       cpu_first = 1'b0;
        endcase
    end

    // Grants: a lone request always wins; no grant while in reset.
    always_comb begin
        gnt[PORT_CPU] = rst_n & req[PORT_CPU] & (~req[PORT_BDR] | cpu_first);
        gnt[PORT_BDR] = rst_n & req[PORT_BDR] & (~req[PORT_CPU] | ~cpu_first);
    end

    // History: cleared by a processor grant, counts backdoor grants up to RUN_MAX.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bdr_run <= RUN_MAX;
        end else if (gnt[PORT_CPU]) begin
            bdr_run <= '0;
        end else if (gnt[PORT_BDR] && bdr_run != RUN_MAX) begin
            bdr_run <= bdr_run + 1'b1;
        end
    end

    assert_lone_cpu_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req[PORT_CPU] && !req[PORT_BDR]) |-> gnt[PORT_CPU]);

    assert_lone_bdr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req[PORT_BDR] && !req[PORT_CPU]) |-> gnt[PORT_BDR]);

    assert_rr_alternates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (contested && mode == ARB_ROUND &&
         $past(rst_n && contested && mode == ARB_ROUND))
        |-> (gnt[PORT_CPU] != $past(gnt[PORT_CPU])));

    assert_weighted_after_cpu_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (contested && mode == ARB_ROUND_BDR && $past(rst_n && gnt[PORT_CPU]))
        |-> gnt[PORT_BDR]);

    assert_fixed_cpu_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (contested && mode == ARB_FIX_CPU) |-> gnt[PORT_CPU]);

    assert_fixed_bdr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (contested && mode == ARB_FIX_BDR) |-> gnt[PORT_BDR]);

endmodule

// File: rtl/access_mux.sv
// Drives the array from the granted requester and applies the write lock.
// Assumes at most one grant bit is set. A locked write is marked as blocked, so the
// response stage can flag it to the requester.
module access_mux
    import sram_arb_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_PORTS-1:0]          gnt,
    input  logic [NUM_PORTS-1:0]          we,
    input  logic [NUM_PORTS-1:0][AW-1:0]  addr,
    input  logic [NUM_PORTS-1:0][DW-1:0]  wdata,
    input  logic                          wr_lock,
    output logic                          mem_en,
    output logic                          mem_we,
    output logic [AW-1:0]                 mem_addr,
    output logic [DW-1:0]                 mem_wdata,
    output logic [NUM_PORTS-1:0]          blocked
);
    logic sel;

    // Select the granted requester (backdoor when its grant is set).
    always_comb begin
        sel       = gnt[PORT_BDR];
        mem_en    = |gnt;
        mem_addr  = addr[sel];
        mem_wdata = wdata[sel];
        mem_we    = mem_en & we[sel] & ~wr_lock;
    end

    // Per-requester flag for a write refused by the lock.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_block
        assign blocked[p] = gnt[p] & we[p] & wr_lock;
    end

    assert_locked_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lock |-> !mem_we);

    assert_strobe_needs_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> $onehot0(gnt));

endmodule

// File: rtl/resp_route.sv
// Returns read data and write-refused flags to the requester that was granted.
// Assumes a synchronous array whose read word appears one cycle after the access.
// Both the valid strobe and the error flag are registered, so they line up with that word.
module resp_route
    import sram_arb_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_PORTS-1:0]          rd_gnt,
    input  logic [NUM_PORTS-1:0]          blocked,
    input  logic [DW-1:0]                 mem_rdata,
    output logic [NUM_PORTS-1:0]          rvalid,
    output logic [NUM_PORTS-1:0]          err,
    output logic [NUM_PORTS-1:0][DW-1:0]  rdata
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        // One-cycle delayed valid and error strobe for this requester.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rvalid[p] <= 1'b0;
                err[p]    <= 1'b0;
            end else begin
                rvalid[p] <= rd_gnt[p];
                err[p]    <= blocked[p];
            end
        end

        // Present array data only to the requester whose read is returning.
        assign rdata[p] = rvalid[p] ? mem_rdata : '0;
    end

    assert_single_response_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rvalid, err}));

    assert_err_after_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|err) |-> $past(|blocked));

endmodule

// File: rtl/sram_port_arbiter.sv
// Top of the two-requester SRAM arbiter.
// It takes a processor port and a backdoor port and drives one single-ported
// synchronous array, with a run-time policy select and a write lock. One
// instance serves one array; a split memory uses one instance per half.
module sram_port_arbiter
    import sram_arb_pkg::*;
#(
    parameter int AW      = 8,
    parameter int DW      = 16,
    parameter int BDR_RUN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_sel,
    input  logic          wr_lock,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_gnt,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_rvalid,
    output logic          cpu_err,
    input  logic          bdr_req,
    input  logic          bdr_we,
    input  logic [AW-1:0] bdr_addr,
    input  logic [DW-1:0] bdr_wdata,
    output logic          bdr_gnt,
    output logic [DW-1:0] bdr_rdata,
    output logic          bdr_rvalid,
    output logic          bdr_err,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    logic [NUM_PORTS-1:0]         req, we, gnt, blocked, rvalid, err;
    logic [NUM_PORTS-1:0][AW-1:0] addr;
    logic [NUM_PORTS-1:0][DW-1:0] wdata, rdata;

    // Gather the two requesters into indexed vectors.
    assign req   = {bdr_req, cpu_req};
    assign we    = {bdr_we, cpu_we};
    assign addr  = {bdr_addr, cpu_addr};
    assign wdata = {bdr_wdata, cpu_wdata};

    arb_policy #(.BDR_RUN(BDR_RUN)) u_policy (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (arb_mode_e'(mode_sel)),
        .req   (req),
        .gnt   (gnt)
    );

    access_mux #(.AW(AW), .DW(DW)) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .gnt       (gnt),
        .we        (we),
        .addr      (addr),
        .wdata     (wdata),
        .wr_lock   (wr_lock),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .blocked   (blocked)
    );

    resp_route #(.DW(DW)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_gnt    (gnt & ~we),
        .blocked   (blocked),
        .mem_rdata (mem_rdata),
        .rvalid    (rvalid),
        .err       (err),
        .rdata     (rdata)
    );

    // Split the indexed responses back onto the named ports.
    assign cpu_gnt    = gnt[PORT_CPU];
    assign bdr_gnt    = gnt[PORT_BDR];
    assign cpu_rvalid = rvalid[PORT_CPU];
    assign bdr_rvalid = rvalid[PORT_BDR];
    assign cpu_err    = err[PORT_CPU];
    assign bdr_err    = err[PORT_BDR];
    assign cpu_rdata  = rdata[PORT_CPU];
    assign bdr_rdata  = rdata[PORT_BDR];

endmodule

// File: tb/sram_port_arbiter_test.sv
`timescale 1ns/100ps
// Bench for the two-requester SRAM arbiter, with a behavioural synchronous array.
module sram_port_arbiter_test;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int NVEC = 28;

    // Row layout: {mode[1:0], cpu_req, bdr_req, exp_cpu_gnt, exp_bdr_gnt}.
    // All requests in the table are reads; the expected winners follow the history
    // left by the rows above each one.
    localparam logic [5:0] VEC [NVEC] = '{
        6'b00_11_10, 6'b00_11_01, 6'b00_11_10, 6'b00_00_00,
        6'b00_10_10, 6'b00_11_01, 6'b00_01_01, 6'b00_11_10,
        6'b01_11_01, 6'b01_11_01, 6'b01_11_10, 6'b01_11_01,
        6'b01_11_01, 6'b01_11_10, 6'b01_10_10, 6'b10_11_10,
        6'b10_11_10, 6'b10_01_01, 6'b11_11_01, 6'b11_11_01,
        6'b11_10_10, 6'b00_11_01, 6'b01_11_01, 6'b00_11_10,
        6'b11_00_00, 6'b01_01_01, 6'b10_01_01, 6'b01_11_10
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    mode_sel;
    logic          wr_lock;
    logic          cpu_req, cpu_we, bdr_req, bdr_we;
    logic [AW-1:0] cpu_addr, bdr_addr, mem_addr;
    logic [DW-1:0] cpu_wdata, bdr_wdata, mem_wdata, mem_rdata;
    logic [DW-1:0] cpu_rdata, bdr_rdata;
    logic          cpu_gnt, bdr_gnt, cpu_rvalid, bdr_rvalid, cpu_err, bdr_err;
    logic          mem_en, mem_we;
    logic [DW-1:0] mem_array [1 << AW];

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    sram_port_arbiter #(.AW(AW), .DW(DW), .BDR_RUN(2)) uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .wr_lock(wr_lock),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_gnt(cpu_gnt), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid), .cpu_err(cpu_err),
        .bdr_req(bdr_req), .bdr_we(bdr_we), .bdr_addr(bdr_addr), .bdr_wdata(bdr_wdata),
        .bdr_gnt(bdr_gnt), .bdr_rdata(bdr_rdata), .bdr_rvalid(bdr_rvalid), .bdr_err(bdr_err),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // Behavioural single-port array: write, or register a read word for the next cycle.
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem_array[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem_array[mem_addr];
        end
    end

    function automatic logic [DW-1:0] init_word(input logic [AW-1:0] a);
        return {a, ~a};
    endfunction

    task automatic check(input string rq, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", rq, got, exp);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [1:0] prev_g;
        string      rq;
        for (int a = 0; a < (1 << AW); a++) mem_array[a] = init_word(AW'(a));
        mem_rdata = '0;
        rst_n = 1'b0; mode_sel = 2'b00; wr_lock = 1'b0;
        cpu_req = 1'b1; bdr_req = 1'b1; cpu_we = 1'b0; bdr_we = 1'b0;
        cpu_addr = 8'h11; bdr_addr = 8'h22; cpu_wdata = '0; bdr_wdata = '0;

        // R1: no grant during reset even with both requests high.
        repeat (2) @(negedge clk);
        #1;
        check("R1 gnt in reset", {30'd0, cpu_gnt, bdr_gnt}, 32'd0);
        check("R1 mem_en in reset", {31'd0, mem_en}, 32'd0);
        @(negedge clk);
        cpu_req = 1'b0; bdr_req = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        check("R1 responses after reset", {28'd0, cpu_rvalid, bdr_rvalid, cpu_err, bdr_err}, 32'd0);

        // Table walk: policies R3..R6, lone requests R2, mode change R9, read return R8.
        prev_g = 2'b00;
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            check("R8 rvalid routing", {30'd0, cpu_rvalid, bdr_rvalid}, {30'd0, prev_g});
            if (prev_g[1]) check("R8 cpu rdata", {16'd0, cpu_rdata}, {16'd0, init_word(8'h11)});
            if (prev_g[0]) check("R8 bdr rdata", {16'd0, bdr_rdata}, {16'd0, init_word(8'h22)});
            mode_sel = VEC[i][5:4];
            cpu_req  = VEC[i][3];
            bdr_req  = VEC[i][2];
            #1;
            if (VEC[i][3] && VEC[i][2]) begin
                case (VEC[i][5:4])
                    2'b00:   rq = "R3 round robin";
                    2'b01:   rq = "R4 weighted";
                    2'b10:   rq = "R5 cpu first";
                    default: rq = "R6 bdr first";
                endcase
            end else begin
                rq = "R2 lone request";
            end
            if (i == 21 || i == 22) rq = "R9 history kept across mode change";
            check(rq, {30'd0, cpu_gnt, bdr_gnt}, {30'd0, VEC[i][1:0]});
            check("R2 mem_en", {31'd0, mem_en}, {31'd0, |VEC[i][1:0]});
            if (VEC[i][1]) check("R10 cpu address", {24'd0, mem_addr}, 32'h11);
            if (VEC[i][0]) check("R10 bdr address", {24'd0, mem_addr}, 32'h22);
            prev_g = VEC[i][1:0];
        end
        @(negedge clk);
        check("R8 last rvalid", {30'd0, cpu_rvalid, bdr_rvalid}, {30'd0, prev_g});
        cpu_req = 1'b0; bdr_req = 1'b0;

        // R10: unlocked processor write to address 5.
        @(negedge clk);
        mode_sel = 2'b00; wr_lock = 1'b0;
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 8'h05; cpu_wdata = 16'hA5A5;
        #1;
        check("R10 write strobe", {31'd0, mem_we}, 32'd1);
        check("R10 write data", {16'd0, mem_wdata}, 32'hA5A5);

        // R7: locked backdoor write to the same address.
        @(negedge clk);
        check("R7 no error when unlocked", {31'd0, cpu_err}, 32'd0);
        check("R8 no valid after write", {30'd0, cpu_rvalid, bdr_rvalid}, 32'd0);
        cpu_req = 1'b0; cpu_we = 1'b0;
        wr_lock = 1'b1; bdr_req = 1'b1; bdr_we = 1'b1; bdr_addr = 8'h05; bdr_wdata = 16'h1234;
        #1;
        check("R7 locked write granted", {31'd0, bdr_gnt}, 32'd1);
        check("R7 locked write suppressed", {31'd0, mem_we}, 32'd0);

        // R7: error flag, then read back the unchanged word.
        @(negedge clk);
        check("R7 error flag", {30'd0, cpu_err, bdr_err}, 32'd1);
        bdr_we = 1'b0;
        @(negedge clk);
        check("R7 error lasts one cycle", {31'd0, bdr_err}, 32'd0);
        check("R8 bdr read valid", {30'd0, cpu_rvalid, bdr_rvalid}, 32'd1);
        check("R7 word unchanged", {16'd0, bdr_rdata}, 32'hA5A5);
        bdr_req = 1'b0; wr_lock = 1'b0;

        // R10: unlocked backdoor write, processor reads it back.
        @(negedge clk);
        bdr_req = 1'b1; bdr_we = 1'b1; bdr_addr = 8'h06; bdr_wdata = 16'h0F0F;
        #1;
        check("R10 bdr write strobe", {31'd0, mem_we}, 32'd1);
        @(negedge clk);
        bdr_req = 1'b0; bdr_we = 1'b0;
        cpu_req = 1'b1; cpu_addr = 8'h06;
        @(negedge clk);
        cpu_req = 1'b0;
        check("R8 cpu read of bdr write", {16'd0, cpu_rdata}, 32'h0F0F);
        check("R8 cpu valid only", {30'd0, cpu_rvalid, bdr_rvalid}, 32'd2);
        @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule